// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 interrupt sources, organised as two banks of 32, and presents them to a processor as two request lines: a fast request and a normal request. Each source is latched on its rising edge into a pending bit. The pending bit stays set until software writes a one to acknowledge it. A per-source enable bit gates the pending bit onto the outputs. A per-source 3-bit priority chooses both the output line and the urgency. Values 0 and 1 select the fast line, values 2 to 7 select the normal line, and a lower value is more urgent.

For the normal line the block computes an entry address for the winning source. The address is a programmable base plus four times the source number plus one, so the offset 0 means that nothing is waiting. Software reads the entry word, shifts it right by two, subtracts one and has the source number. All state sits behind a simple 32-bit register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all pending and enable bits are 0, the entry base is 0, the control word is 0, every priority field is 7 (each priority word reads 0x77777777), both request outputs are low and the entry word at 0x14 reads 0.
- R2: A source becomes pending on a rising edge of its input. A level held high after an acknowledge does not set it again.
- R3: Writing 1 to a status bit clears that source's pending bit, and writing 0 leaves it unchanged. If a new rising edge and a clear of the same source fall in the same cycle, the source stays pending.
- R4: Enable bits live at 0x18 (sources 0 to 31) and 0x1C (sources 32 to 63), where bit b belongs to source 32×bank+b. A masked source still shows as pending in status but drives no output and is not chosen for the entry word. Clearing the enable bit drops the request in the next cycle.
- R5: A source with priority 0 or 1 is routed to the fast path and reads at 0x00/0x04. A source with priority 2 to 7 is routed to the normal path and reads at 0x08/0x0C. A write-one-to-clear to a fast status word clears only fast-routed sources, and a write to a normal status word clears only normal-routed sources.
- R6: fiq_o is high exactly when an enabled pending fast-routed source exists. irq_o is the same for normal-routed sources.
- R7: The entry word reads base + (n+1)×4 for the winning normal-routed source n, and reads base when no source is eligible.
- R8: Among eligible normal-routed sources the lowest priority value wins. On a tie, the lowest source number wins.
- R9: Priority word r at 0x30+4r holds sources 8r to 8r+7. Source 8r+k uses bits [4k+2:4k], and bit 4k+3 always reads 0.
- R10: The entry base at 0x24 is a full 32-bit read/write word. The control word at 0x20 keeps bits [1:0] and reads 0 in its other bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Single-source pulses in both banks show that latching, acknowledge and enable gating work one bit at a time. A masked source that is then unmasked shows that status and output are gated separately. A pending source that is cleared in the same cycle as a fresh edge tells edge precedence apart from clear precedence, and a level held high through an acknowledge tells edge detection apart from level sensing. Three sources are raised together, with two at equal priority and one more urgent in the other bank, and then acknowledged one at a time. This separates ordering by priority from ordering by index. A fast-routed source that is acknowledged through the wrong status word shows that the clear respects routing.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int AW   = 8,
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int NBANK = NSRC / 32;
  localparam int NPRI  = NSRC / 8;
  localparam int IDXW  = $clog2(NSRC);

  logic [NSRC-1:0] src_q, pend, en, fiq_rt, rise, clr_f, clr_n, clear, cand;
  logic [2:0]      prio [NSRC];
  logic [1:0]      ctl;
  logic [31:0]     base, entry;
  logic [IDXW-1:0] best_i;
  logic [3:0]      best_p;
  logic            found;

  assign rise = src_i & ~src_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign clr_f[b*32 +: 32] = (wr_en_i && addr_i == AW'(4*b))     ? wdata_i : '0;
    assign clr_n[b*32 +: 32] = (wr_en_i && addr_i == AW'(8 + 4*b)) ? wdata_i : '0;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_rt
    assign fiq_rt[i] = prio[i] < 3'd2;
  end

  assign clear = (clr_f & fiq_rt) | (clr_n & ~fiq_rt);
  assign cand  = pend & en & ~fiq_rt;
  assign irq_o = |cand;
  assign fiq_o = |(pend & en & fiq_rt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      en    <= '0;
      ctl   <= '0;
      base  <= '0;
      for (int i = 0; i < NSRC; i++) prio[i] <= 3'd7;
    end else begin
      src_q <= src_i;
      pend  <= (pend & ~clear) | rise;
      if (wr_en_i) begin
        for (int b = 0; b < NBANK; b++)
          if (addr_i == AW'(8'h18 + 4*b)) en[b*32 +: 32] <= wdata_i;
        if (addr_i == AW'(8'h20)) ctl <= wdata_i[1:0];
        if (addr_i == AW'(8'h24)) base <= wdata_i;
        for (int r = 0; r < NPRI; r++)
          if (addr_i == AW'(8'h30 + 4*r))
            for (int k = 0; k < 8; k++) prio[8*r+k] <= wdata_i[4*k +: 3];
      end
    end
  end

  always_comb begin
    best_p = 4'd8;
    best_i = '0;
    found  = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && {1'b0, prio[i]} < best_p) begin
        best_p = {1'b0, prio[i]};
        best_i = IDXW'(i);
        found  = 1'b1;
      end
  end

  assign entry = base + (found ? ((32'(best_i) + 32'd1) << 2) : 32'd0);

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (addr_i == AW'(4*b))         rdata_o = pend[b*32 +: 32] & fiq_rt[b*32 +: 32];
      if (addr_i == AW'(8 + 4*b))     rdata_o = pend[b*32 +: 32] & ~fiq_rt[b*32 +: 32];
      if (addr_i == AW'(8'h18 + 4*b)) rdata_o = en[b*32 +: 32];
    end
    if (addr_i == AW'(8'h14)) rdata_o = entry;
    if (addr_i == AW'(8'h20)) rdata_o = {30'd0, ctl};
    if (addr_i == AW'(8'h24)) rdata_o = base;
    for (int r = 0; r < NPRI; r++)
      if (addr_i == AW'(8'h30 + 4*r))
        for (int k = 0; k < 8; k++) rdata_o[4*k +: 4] = {1'b0, prio[8*r+k]};
  end
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_i,
  input logic [7:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic        fiq_o,
  input logic [63:0] pend,
  input logic [63:0] en,
  input logic [31:0] entry,
  input logic [31:0] base
);
  logic [63:0] src_d, rise_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_d  <= '0;
      rise_d <= '0;
    end else begin
      src_d  <= src_i;
      rise_d <= src_i & ~src_d;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!irq_o && !fiq_o)); // R1
  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) (pend & rise_d) == rise_d); // R2
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n) (en == '0) |-> (!irq_o && !fiq_o)); // R4
  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq_o |-> (entry == base)); // R7
  AST_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (entry != base)); // R7
  AST_PRIO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i >= 8'h30 && addr_i <= 8'h4C && addr_i[1:0] == 2'b00) |-> ((rdata_o & 32'h8888_8888) == 32'd0)); // R9
endmodule

bind prio_vec_intc prio_vec_intc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .fiq_o(fiq_o), .pend(pend), .en(en), .entry(entry), .base(base)
);

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0;
  endtask

  task automatic cleanup();
    wr_reg(8'h18, 0); wr_reg(8'h1C, 0); wr_reg(8'h24, 0);
    for (int r = 0; r < 8; r++) wr_reg(8'(8'h30 + 4*r), 32'h7777_7777);
    wr_reg(8'h00, '1); wr_reg(8'h04, '1); wr_reg(8'h08, '1); wr_reg(8'h0C, '1);
  endtask

  task automatic t_reset();
    rd_chk("R1 irq status", 8'h08, 0);
    rd_chk("R1 enable", 8'h1C, 0);
    rd_chk("R1 prio", 8'h44, 32'h7777_7777);
    rd_chk("R1 entry", 8'h14, 0);
    rd_chk("R10 ctl", 8'h20, 0);
    chk("R1 outputs", {30'd0, irq, fiq}, 0);
  endtask

  task automatic t_latch_ack();
    pulse(4);
    rd_chk("R2 latched", 8'h08, 32'h10);
    wr_reg(8'h08, 32'h0);
    rd_chk("R3 zero write", 8'h08, 32'h10);
    wr_reg(8'h08, 32'h10);
    rd_chk("R3 cleared", 8'h08, 0);
    @(negedge clk); src[7] = 1'b1;
    wr_reg(8'h08, 32'h80);
    rd_chk("R2 level held", 8'h08, 0);
    src[7] = 1'b0;
    pulse(3);
    @(negedge clk); src[3] = 1'b1; wr = 1'b1; addr = 8'h08; wdata = 32'h8;
    @(negedge clk); wr = 1'b0; src[3] = 1'b0;
    rd_chk("R3 edge beats clear", 8'h08, 32'h8);
    pulse(63);
    rd_chk("R2 bank1", 8'h0C, 32'h8000_0000);
    cleanup();
  endtask

  task automatic t_enable();
    pulse(5);
    rd_chk("R4 masked pending", 8'h08, 32'h20);
    chk("R4 masked irq", {31'd0, irq}, 0);
    rd_chk("R4 masked entry", 8'h14, 0);
    wr_reg(8'h18, 32'h20);
    chk("R6 irq up", {31'd0, irq}, 1);
    rd_chk("R7 entry", 8'h14, 32'd24);
    wr_reg(8'h18, 32'h0);
    chk("R4 disable drops", {31'd0, irq}, 0);
    cleanup();
  endtask

  task automatic t_route();
    wr_reg(8'h40, 32'h7777_7717);
    wr_reg(8'h1C, 32'h2);
    pulse(33);
    chk("R6 fiq", {30'd0, irq, fiq}, 32'h1);
    rd_chk("R5 fiq status", 8'h04, 32'h2);
    rd_chk("R5 irq status", 8'h0C, 0);
    rd_chk("R7 fiq not in entry", 8'h14, 0);
    wr_reg(8'h0C, 32'h2);
    rd_chk("R5 wrong word", 8'h04, 32'h2);
    wr_reg(8'h04, 32'h2);
    rd_chk("R5 right word", 8'h04, 0);
    chk("R6 fiq down", {31'd0, fiq}, 0);
    cleanup();
  endtask

  task automatic t_arb();
    wr_reg(8'h18, '1); wr_reg(8'h1C, '1);
    wr_reg(8'h48, 32'h7777_7277);
    wr_reg(8'h34, 32'h7777_7377);
    wr_reg(8'h44, 32'h7777_7773);
    @(negedge clk); src[10] = 1'b1; src[40] = 1'b1; src[50] = 1'b1;
    @(negedge clk); src = '0;
    rd_chk("R8 best prio", 8'h14, 32'd204);
    wr_reg(8'h0C, 32'h1 << 18);
    rd_chk("R8 tie low index", 8'h14, 32'd44);
    wr_reg(8'h08, 32'h1 << 10);
    rd_chk("R8 last", 8'h14, 32'd164);
    wr_reg(8'h0C, 32'h1 << 8);
    rd_chk("R7 none", 8'h14, 0);
    cleanup();
  endtask

  task automatic t_base();
    wr_reg(8'h24, 32'h0000_1000);
    rd_chk("R10 base", 8'h24, 32'h1000);
    rd_chk("R7 idle base", 8'h14, 32'h1000);
    wr_reg(8'h18, 32'h1);
    pulse(0);
    rd_chk("R7 base offset", 8'h14, 32'h1004);
    cleanup();
  endtask

  task automatic t_fields();
    wr_reg(8'h4C, '1);
    rd_chk("R9 reserved bits", 8'h4C, 32'h7777_7777);
    wr_reg(8'h30, 32'h0123_4567);
    rd_chk("R9 fields", 8'h30, 32'h0123_4567);
    wr_reg(8'h20, '1);
    rd_chk("R10 ctl width", 8'h20, 32'h3);
    rd_chk("R10 unmapped", 8'h10, 0);
    wr_reg(8'h20, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_ack();
    t_enable();
    t_route();
    t_arb();
    t_base();
    t_fields();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule